// File: doc/BRIEF.md
# True-Time-Delay Tile Beamformer

This block forms one time-domain beam per polarisation from a tile of dual-polarisation antennas. Every clock it takes one signed sample from each of the 32 streams (16 elements times two polarisations). It delays each stream by its own steering delay. The whole-sample part of that delay is applied by picking a tap from a per-stream history line. The fractional part is applied by linear interpolation between that tap and the one sample older. The interpolated streams of each polarisation are added together at full precision, then rounded and clamped to a 12-bit signed beam sample.

Steering coefficients are loaded through a simple write port into a shadow bank. A single load strobe moves the whole bank into use on one clock edge, so no beam sample ever mixes old and new steering. The output-valid flag stays low until the history lines hold enough real samples for the deepest possible tap. The pipeline latency is fixed and is presented on an output port next to the valid flag.

Top module: `ttd_tile_beamformer`

## Requirements
- R1: While reset is held, `out_valid` is 0, both beam outputs are 0, and `out_latency` reads 3.
- R2: Stream s occupies bits [8s+7:8s] of `samp_in` and belongs to element s/2. Even streams (s%2 = 0) are summed into `beam_p0` and odd streams into `beam_p1`. A stream never affects the other polarisation's beam.
- R3: With integer delay k for a stream, the sample captured at clock edge n contributes to the beam output that is visible after edge n+k+3.
- R4: Each stream contributes y = x[n-k]*(16-f) + x[n-k-1]*f, where k is the 5-bit integer delay (0..31), f is the 4-bit fraction (0..15), and x[m] is the sample captured at edge m.
- R5: Each beam equals floor((S+8)/16), where S is the sum of y over the polarisation's 16 streams, clamped to the range -2048..2047.
- R6: When `cfg_we` is high at an edge, the shadow coefficient of stream `cfg_addr` is set to `cfg_wdata`, with the integer delay in bits [8:4] and the fraction in bits [3:0]. Shadow writes have no effect on the beams until a load.
- R7: When `cfg_load` is high at edge n, every stream switches to its shadow coefficient, starting with the output for the sample captured at edge n. A write in the same cycle lands in the shadow only after the copy has been made.
- R8: After reset, the output for the sample captured at the m-th edge (m counted from 1) is marked valid only if m >= 33.
- R9: A load that raises the integer delay of any stream marks the outputs for the sample at the load edge and for the next 32 samples invalid. A load that only keeps or lowers integer delays leaves validity unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per stream per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_in | input | 256 | 32 signed 8-bit samples, stream s at bits [8s+7:8s] |
| cfg_we | input | 1 | Shadow coefficient write enable |
| cfg_addr | input | 5 | Stream index for the write |
| cfg_wdata | input | 9 | Coefficient: integer delay [8:4], fraction [3:0] |
| cfg_load | input | 1 | Copy the whole shadow bank into the active bank |
| beam_p0 | output | 12 | Signed beam of the even streams |
| beam_p1 | output | 12 | Signed beam of the odd streams |
| out_valid | output | 1 | Beam outputs carry a valid sample |
| out_latency | output | 8 | Fixed pipeline latency in clocks (3) |

## Verification
The result for a sample driven before capture edge n is due three edges later, after edge n+3. The steering taps then reach back k and k+1 samples from n. The bench tags each expected pair of beams with that due edge and compares it half a clock after the edge, so the design's outputs are never sampled at an edge. A load applies to the output of its own capture edge. The expected validity is therefore recomputed from a history count that is cleared on growth at that same capture edge, so the valid flag's fall and rise are checked on the exact cycle they are due.

// File: rtl/ttdbf_pkg.sv
package ttdbf_pkg;

   localparam int SAMP_W_DEF = 8;
   localparam int INT_W_DEF  = 5;
   localparam int FRAC_W_DEF = 4;
   localparam int N_ELEM_DEF = 16;
   localparam int OUT_W_DEF  = 12;

   // width of one interpolated term: sample width plus weight width
   function automatic int term_width(input int samp_w, input int frac_w);
      return samp_w + frac_w + 1;
   endfunction

endpackage

// File: rtl/ttd_coef_bank.sv
module ttd_coef_bank #(
   parameter int N_STREAM = 32,
   parameter int INT_W    = 5,
   parameter int FRAC_W   = 4,
   parameter int ADDR_W   = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [INT_W+FRAC_W-1:0]          wr_data,
   input  logic                             load,
   output logic [N_STREAM-1:0][INT_W-1:0]   act_int,
   output logic [N_STREAM-1:0][FRAC_W-1:0]  act_frac,
   output logic                             grow
);

   logic [N_STREAM-1:0][INT_W-1:0]  sh_int;
   logic [N_STREAM-1:0][FRAC_W-1:0] sh_frac;
   logic [N_STREAM-1:0]             grows;

   for (genvar s = 0; s < N_STREAM; s++) begin : g_stream
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh_int[s]  <= '0;
            sh_frac[s] <= '0;
         end else if (wr_en && (wr_addr == ADDR_W'(s))) begin
            sh_int[s]  <= wr_data[INT_W+FRAC_W-1:FRAC_W];
            sh_frac[s] <= wr_data[FRAC_W-1:0];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_int[s]  <= '0;
            act_frac[s] <= '0;
         end else if (load) begin
            act_int[s]  <= sh_int[s];
            act_frac[s] <= sh_frac[s];
         end
      end

      assign grows[s] = (sh_int[s] > act_int[s]);
   end

   assign grow = |grows;

   // R7: a load moves the shadow bank into use on the same edge
   a_r7_load_takes_shadow: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (act_int == $past(sh_int)) && (act_frac == $past(sh_frac)));

   // R6: without a load the active steering never moves
   a_r6_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(act_int) && $stable(act_frac));

endmodule

// File: rtl/ttd_delay_tap.sv
module ttd_delay_tap #(
   parameter int SAMP_W = 8,
   parameter int INT_W  = 5,
   parameter int FRAC_W = 4,
   parameter int IW     = 13
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [SAMP_W-1:0] samp,
   input  logic [INT_W-1:0]         k,
   input  logic [FRAC_W-1:0]        f,
   output logic signed [IW-1:0]     y
);

   localparam int DEPTH = (1 << INT_W) + 1;
   localparam int IDX_W = $clog2(DEPTH);
   localparam logic [FRAC_W:0] ONE = (FRAC_W+1)'(1 << FRAC_W);

   logic signed [SAMP_W-1:0] hist [DEPTH];
   logic signed [SAMP_W-1:0] near_s, far_s, newest;
   logic [IDX_W-1:0]         idx_near, idx_far;
   logic [FRAC_W:0]          w_far, w_near;
   logic signed [IW-1:0]     near_x, far_x, wn_x, wf_x, mix;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int j = 0; j < DEPTH; j++) hist[j] <= '0;
      end else begin
         hist[0] <= samp;
         for (int j = 1; j < DEPTH; j++) hist[j] <= hist[j-1];
      end
   end

   assign newest   = hist[0];
   assign idx_near = IDX_W'(k);
   assign idx_far  = IDX_W'(k) + IDX_W'(1);
   assign near_s   = hist[idx_near];
   assign far_s    = hist[idx_far];

   assign w_far  = {1'b0, f};
   assign w_near = ONE - w_far;

   always_comb begin
      near_x = IW'(near_s);
      far_x  = IW'(far_s);
      wn_x   = $signed(IW'(w_near));
      wf_x   = $signed(IW'(w_far));
      mix    = near_x * wn_x + far_x * wf_x;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) y <= '0;
      else        y <= mix;
   end

   // R4: zero delay and zero fraction passes the newest sample at unit weight
   a_r4_zero_tap_scaled: assert property (@(posedge clk) disable iff (!rst_n)
      (k == '0 && f == '0) |=> (y == (IW'($past(newest)) <<< FRAC_W)));

endmodule

// File: rtl/ttd_pol_sum.sv
module ttd_pol_sum #(
   parameter int N_TERM = 16,
   parameter int IW     = 13,
   parameter int FRAC_W = 4,
   parameter int OUT_W  = 12
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_TERM-1:0][IW-1:0]   terms,
   output logic signed [OUT_W-1:0]     beam
);

   localparam int SW = IW + $clog2(N_TERM);
   localparam logic signed [SW-1:0] MAX_V = SW'((1 << (OUT_W-1)) - 1);
   localparam logic signed [SW-1:0] MIN_V = -MAX_V - SW'(1);

   if (OUT_W > SW) begin : g_bad_width
      $error("ttd_pol_sum: OUT_W wider than the accumulator");
   end

   logic signed [SW-1:0] acc_d, acc_q, scaled;
   logic signed [OUT_W-1:0] beam_d;

   always_comb begin
      acc_d = '0;
      for (int i = 0; i < N_TERM; i++) acc_d = acc_d + SW'($signed(terms[i]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
   end

   if (FRAC_W > 0) begin : g_round
      localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FRAC_W-1);
      logic signed [SW-1:0] biased;
      assign biased = acc_q + HALF;
      assign scaled = biased >>> FRAC_W;
   end else begin : g_noround
      assign scaled = acc_q;
   end

   always_comb begin
      if (scaled > MAX_V)      beam_d = MAX_V[OUT_W-1:0];
      else if (scaled < MIN_V) beam_d = MIN_V[OUT_W-1:0];
      else                     beam_d = scaled[OUT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) beam <= '0;
      else        beam <= beam_d;
   end

   // R5: a positive full-precision sum never produces a negative beam
   a_r5_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q > 0) |=> (beam >= 0));

endmodule

// File: rtl/ttd_tile_beamformer.sv
module ttd_tile_beamformer
   import ttdbf_pkg::*;
#(
   parameter int N_ELEM = N_ELEM_DEF,
   parameter int SAMP_W = SAMP_W_DEF,
   parameter int INT_W  = INT_W_DEF,
   parameter int FRAC_W = FRAC_W_DEF,
   parameter int OUT_W  = OUT_W_DEF
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [2*N_ELEM*SAMP_W-1:0]        samp_in,
   input  logic                              cfg_we,
   input  logic [$clog2(2*N_ELEM)-1:0]       cfg_addr,
   input  logic [INT_W+FRAC_W-1:0]           cfg_wdata,
   input  logic                              cfg_load,
   output logic signed [OUT_W-1:0]           beam_p0,
   output logic signed [OUT_W-1:0]           beam_p1,
   output logic                              out_valid,
   output logic [7:0]                        out_latency
);

   localparam int N_POL    = 2;
   localparam int N_STREAM = N_POL * N_ELEM;
   localparam int ADDR_W   = $clog2(N_STREAM);
   localparam int IW       = term_width(SAMP_W, FRAC_W);
   localparam int DEPTH    = (1 << INT_W) + 1;
   localparam int FILL_W   = $clog2(DEPTH + 1);
   localparam int LAT      = 3;

   if (N_ELEM < 2) begin : g_bad_elem
      $error("ttd_tile_beamformer: N_ELEM must be at least 2");
   end
   if (SAMP_W < 2 || INT_W < 1) begin : g_bad_size
      $error("ttd_tile_beamformer: sample or delay width too small");
   end

   logic [N_STREAM-1:0][INT_W-1:0]  act_int;
   logic [N_STREAM-1:0][FRAC_W-1:0] act_frac;
   logic                            grow;
   logic [N_STREAM-1:0][IW-1:0]     terms;
   logic [N_POL-1:0][N_ELEM-1:0][IW-1:0] pol_terms;
   logic signed [OUT_W-1:0]         beams [N_POL];
   logic [FILL_W-1:0]               fill;
   logic                            fill_full;
   logic [LAT-1:0]                  v_pipe;

   ttd_coef_bank #(
      .N_STREAM (N_STREAM),
      .INT_W    (INT_W),
      .FRAC_W   (FRAC_W),
      .ADDR_W   (ADDR_W)
   ) u_coef (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_addr  (cfg_addr),
      .wr_data  (cfg_wdata),
      .load     (cfg_load),
      .act_int  (act_int),
      .act_frac (act_frac),
      .grow     (grow)
   );

   for (genvar s = 0; s < N_STREAM; s++) begin : g_tap
      ttd_delay_tap #(
         .SAMP_W (SAMP_W),
         .INT_W  (INT_W),
         .FRAC_W (FRAC_W),
         .IW     (IW)
      ) u_tap (
         .clk   (clk),
         .rst_n (rst_n),
         .samp  ($signed(samp_in[s*SAMP_W +: SAMP_W])),
         .k     (act_int[s]),
         .f     (act_frac[s]),
         .y     (terms[s])
      );
      assign pol_terms[s % N_POL][s / N_POL] = terms[s];
   end

   for (genvar p = 0; p < N_POL; p++) begin : g_pol
      ttd_pol_sum #(
         .N_TERM (N_ELEM),
         .IW     (IW),
         .FRAC_W (FRAC_W),
         .OUT_W  (OUT_W)
      ) u_sum (
         .clk   (clk),
         .rst_n (rst_n),
         .terms (pol_terms[p]),
         .beam  (beams[p])
      );
   end

   assign beam_p0 = beams[0];
   assign beam_p1 = beams[1];

   // history fill: counts captured samples up to the deepest tap
   always_ff @(posedge clk) begin
      if (!rst_n)                           fill <= '0;
      else if (cfg_load && grow)            fill <= '0;
      else if (fill != FILL_W'(DEPTH))      fill <= fill + FILL_W'(1);
   end

   assign fill_full = (fill == FILL_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) v_pipe <= '0;
      else        v_pipe <= {v_pipe[LAT-2:0], fill_full};
   end

   assign out_valid   = v_pipe[LAT-1];
   assign out_latency = 8'(LAT);

   // R8: valid only follows a full history three edges earlier
   a_r8_valid_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(fill_full, 3));

   // R9: a full history is lost only through a load
   a_r9_drop_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fill_full) |-> $past(cfg_load));

   // R8: once full, the history stays full without a load
   a_r8_full_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_full && !cfg_load) |=> fill_full);

endmodule

// File: tb/ttd_tile_beamformer_tb.sv
module ttd_tile_beamformer_tb;

   localparam int NS = 32;
   localparam int VW = NS * 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [VW-1:0] samp_in;
   logic          cfg_we;
   logic [4:0]    cfg_addr;
   logic [8:0]    cfg_wdata;
   logic          cfg_load;
   logic signed [11:0] beam_p0, beam_p1;
   logic          out_valid;
   logic [7:0]    out_latency;

   always #5 clk = ~clk;

   ttd_tile_beamformer u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .samp_in     (samp_in),
      .cfg_we      (cfg_we),
      .cfg_addr    (cfg_addr),
      .cfg_wdata   (cfg_wdata),
      .cfg_load    (cfg_load),
      .beam_p0     (beam_p0),
      .beam_p1     (beam_p1),
      .out_valid   (out_valid),
      .out_latency (out_latency)
   );

   typedef struct {
      int    due;
      int    ex;
      int    ey;
      bit    ev;
      string tag;
   } item_t;

   item_t q[$];
   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   int mh [NS][33];
   int sh_i [NS];
   int sh_f [NS];
   int ac_i [NS];
   int ac_f [NS];
   int mfill = 0;
   int ni [NS];
   int nf [NS];

   always @(posedge clk) cyc = cyc + 1;

   task automatic check(input string req, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d (edge %0d)", req, what, got, exp, cyc);
      end
   endtask

   function automatic int clamp_round(input int s);
      int r;
      r = (s + 8) >>> 4;
      if (r > 2047)  r = 2047;
      if (r < -2048) r = -2048;
      return r;
   endfunction

   function automatic logic [VW-1:0] rnd_vec(input int mask);
      logic [VW-1:0] v;
      for (int s = 0; s < NS; s++) begin
         v[8*s +: 8] = ((mask >> (s % 2)) & 1) ? 8'($urandom) : 8'h00;
      end
      return v;
   endfunction

   function automatic logic [VW-1:0] const_vec(input logic [7:0] b0, input logic [7:0] b1);
      logic [VW-1:0] v;
      for (int s = 0; s < NS; s++) v[8*s +: 8] = (s % 2 == 0) ? b0 : b1;
      return v;
   endfunction

   // driver: sets inputs for the next capture edge and queues the expected result
   task automatic drive(input logic [VW-1:0] smp, input bit we, input int addr,
                        input int ii, input int ff, input bit ld, input string tag);
      bit grow;
      int ex, ey, y;
      samp_in   = smp;
      cfg_we    = we;
      cfg_addr  = 5'(addr);
      cfg_wdata = {4'(ii) == 4'(ii) ? 5'(ii) : 5'(ii), 4'(ff)};
      cfg_load  = ld;
      grow = 1'b0;
      if (ld) begin
         for (int s = 0; s < NS; s++) begin
            if (sh_i[s] > ac_i[s]) grow = 1'b1;
            ac_i[s] = sh_i[s];
            ac_f[s] = sh_f[s];
         end
      end
      if (we) begin
         sh_i[addr] = ii;
         sh_f[addr] = ff;
      end
      for (int s = 0; s < NS; s++) begin
         for (int j = 32; j > 0; j--) mh[s][j] = mh[s][j-1];
         mh[s][0] = int'($signed(smp[8*s +: 8]));
      end
      if (ld && grow)     mfill = 0;
      else if (mfill < 33) mfill = mfill + 1;
      ex = 0;
      ey = 0;
      for (int s = 0; s < NS; s++) begin
         y = mh[s][ac_i[s]] * (16 - ac_f[s]) + mh[s][ac_i[s] + 1] * ac_f[s];
         if (s % 2 == 0) ex += y;
         else            ey += y;
      end
      q.push_back('{due: cyc + 4, ex: clamp_round(ex), ey: clamp_round(ey),
                    ev: (mfill == 33), tag: tag});
      @(posedge clk);
      #2;
   endtask

   // monitor: compares each queued result half a clock after its due edge
   always @(negedge clk) begin
      if (rst_n && q.size() > 0 && q[0].due == cyc) begin
         item_t it;
         it = q.pop_front();
         check("R8/R9", "out_valid", int'(out_valid), int'(it.ev));
         if (it.ev) begin
            check(it.tag, "beam_p0", int'(beam_p0), it.ex);
            check(it.tag, "beam_p1", int'(beam_p1), it.ey);
         end
      end
   end

   task automatic write_bank(input string tag);
      for (int s = 0; s < NS; s++) drive(rnd_vec(3), 1'b1, s, ni[s], nf[s], 1'b0, tag);
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int s = 0; s < NS; s++) begin
         sh_i[s] = 0; sh_f[s] = 0; ac_i[s] = 0; ac_f[s] = 0;
         for (int j = 0; j < 33; j++) mh[s][j] = 0;
      end
      rst_n = 1'b0;
      samp_in = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; cfg_load = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      // R1: reset state
      samp_in = rnd_vec(3);
      @(negedge clk);
      check("R1", "out_valid", int'(out_valid), 0);
      check("R1", "beam_p0", int'(beam_p0), 0);
      check("R1", "beam_p1", int'(beam_p1), 0);
      check("R1", "out_latency", int'(out_latency), 3);
      @(posedge clk);
      #2;
      rst_n = 1'b1;

      // R3: zero steering, random samples, history fill per R8
      for (int i = 0; i < 40; i++) drive(rnd_vec(3), 1'b0, 0, 0, 0, 1'b0, "R3");
      // R2: polarisation separation
      for (int i = 0; i < 8; i++) drive(rnd_vec(1), 1'b0, 0, 0, 0, 1'b0, "R2");
      for (int i = 0; i < 8; i++) drive(rnd_vec(2), 1'b0, 0, 0, 0, 1'b0, "R2");

      // R6: integer delays into the shadow only, then a growing load (R9)
      for (int s = 0; s < NS; s++) begin ni[s] = (s * 7 + 3) % 32; nf[s] = 0; end
      write_bank("R6");
      drive(rnd_vec(3), 1'b0, 0, 0, 0, 1'b1, "R9");
      for (int i = 0; i < 40; i++) drive(rnd_vec(3), 1'b0, 0, 0, 0, 1'b0, "R3");

      // R4: random integer and fractional delays
      for (int s = 0; s < NS; s++) begin ni[s] = $urandom % 32; nf[s] = $urandom % 16; end
      ni[0] = 31; nf[0] = 9;
      write_bank("R6");
      // R7: load and write in the same cycle; stream 0 keeps the copied value
      drive(rnd_vec(3), 1'b1, 0, 2, 5, 1'b1, "R7");
      for (int i = 0; i < 12; i++) drive(rnd_vec(3), 1'b0, 0, 0, 0, 1'b0, "R7");
      for (int i = 0; i < 40; i++) drive(rnd_vec(3), 1'b0, 0, 0, 0, 1'b0, "R4");

      // R9: a shrinking load keeps the output valid
      for (int s = 0; s < NS; s++) begin ni[s] = 0; nf[s] = $urandom % 16; end
      write_bank("R6");
      drive(rnd_vec(3), 1'b0, 0, 0, 0, 1'b1, "R9");
      for (int i = 0; i < 10; i++) drive(rnd_vec(3), 1'b0, 0, 0, 0, 1'b0, "R9");

      // R5: extreme samples at the deepest tap and largest fraction
      for (int s = 0; s < NS; s++) begin ni[s] = 31; nf[s] = 15; end
      write_bank("R6");
      drive(const_vec(8'h7F, 8'h80), 1'b0, 0, 0, 0, 1'b1, "R5");
      for (int i = 0; i < 36; i++) drive(const_vec(8'h7F, 8'h80), 1'b0, 0, 0, 0, 1'b0, "R5");
      for (int i = 0; i < 8; i++)  drive(const_vec(8'h80, 8'h7F), 1'b0, 0, 0, 0, 1'b0, "R5");
      for (int i = 0; i < 20; i++) drive(rnd_vec(3), 1'b0, 0, 0, 0, 1'b0, "R5");

      for (int i = 0; i < 5; i++) drive('0, 1'b0, 0, 0, 0, 1'b0, "R3");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule